// File: doc/BRIEF.md
# I2C Slave Sub-Address Buffer Pointer Controller

This block holds the byte-level addressing state of an I2C slave that exposes a 32-byte buffer to a bus master. A separate bit-level engine decodes the wire. It hands this block single-cycle event strobes:
- start or repeated start
- stop
- own-address match, together with the direction bit
- a received data byte
- a request for the next byte to transmit

The block keeps two pointers. The base pointer is a sub-address that survives from one transaction to the next. The current pointer walks through the buffer as bytes move.

In a write transaction, the first data byte after the address is not stored. It becomes the new base pointer. Every later byte in that transaction is stored at the current pointer, which then advances. A read reuses whatever base pointer the last write left behind, so the master can fetch data without resending the sub-address. The current pointer reloads from the base pointer on every address match. Both pointers are visible to the host as read-only outputs.

Top module: `i2c_bufptr_ctrl`

## Requirements
- R1: After reset, base_ptr_o and cur_ptr_o are 0 and every buffer byte reads as 0.
- R2: In a write transaction (address match with rw_i=0), the first received byte loads bits [4:0] into both base and current pointer one cycle later; bits [7:5] are discarded and no buffer byte is written.
- R3: Each later received byte of the same write transaction is stored at the current pointer, and the current pointer then increments by one.
- R4: Every pointer increment wraps modulo 32, so 31 advances to 0.
- R5: On every address match, read or write, cur_ptr_o equals base_ptr_o one cycle later.
- R6: In a read transaction (address match with rw_i=1), tx_byte_o shows the buffer byte at cur_ptr_o in the same cycle that tx_req_i is high, and each tx_req_i strobe advances the current pointer by one.
- R7: A write transaction that carries only the sub-address byte updates the base pointer and leaves the whole buffer unchanged.
- R8: After start_i or stop_i, received bytes and tx_req_i have no effect on either pointer or on the buffer until the next address match.
- R9: The base pointer changes only through the first byte of a write transaction; reads and later data bytes never alter it, and it persists across transactions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or repeated start strobe |
| stop_i | input | 1 | Stop strobe |
| addr_match_i | input | 1 | Own slave address matched strobe |
| rw_i | input | 1 | Direction bit with addr_match_i, 1 = read |
| rx_valid_i | input | 1 | Received data byte strobe |
| rx_byte_i | input | 8 | Received data byte |
| tx_req_i | input | 1 | Request for the next transmit byte |
| tx_byte_o | output | 8 | Transmit byte, buffer content at the current pointer |
| base_ptr_o | output | 5 | Base (sub-address) pointer, host readable |
| cur_ptr_o | output | 5 | Current pointer, host readable |

## Verification
A wrong base pointer shows on base_ptr_o one cycle after the offending event. It also shows on cur_ptr_o one cycle after the next address match, and in the first byte of the next read. A current pointer that skips, fails to wrap or fails to reload sends the wrong byte on the very next tx_req_i. A misplaced write cannot be seen on the pointer outputs; it shows up only when a later read reaches that location. For this reason, every write pattern in the bench is followed by a read-back through the scoreboard. A transaction state that fails to close on stop or start appears as pointer movement on a stray byte or request, visible one cycle later.

// File: rtl/i2c_bufptr_pkg.sv
package i2c_bufptr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SUB   = 2'd1,
    ST_WDATA = 2'd2,
    ST_READ  = 2'd3
  } xfer_st_e;
endpackage

// File: rtl/bufptr_fsm.sv
module bufptr_fsm
  import i2c_bufptr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic addr_match_i,
  input  logic rw_i,
  input  logic rx_valid_i,
  input  logic tx_req_i,
  output logic reload_o,
  output logic load_base_o,
  output logic wr_en_o,
  output logic rd_inc_o
);
  xfer_st_e state_q, state_d;
  logic     end_xfer;

  // bus framing events dominate, then address match, then byte events
  assign end_xfer    = start_i | stop_i;
  assign reload_o    = addr_match_i & ~end_xfer;
  assign load_base_o = (state_q == ST_SUB)   & rx_valid_i & ~end_xfer & ~addr_match_i;
  assign wr_en_o     = (state_q == ST_WDATA) & rx_valid_i & ~end_xfer & ~addr_match_i;
  assign rd_inc_o    = (state_q == ST_READ)  & tx_req_i   & ~end_xfer & ~addr_match_i;

  always_comb begin
    state_d = state_q;
    if (end_xfer)          state_d = ST_IDLE;
    else if (addr_match_i) state_d = rw_i ? ST_READ : ST_SUB;
    else if (load_base_o)  state_d = ST_WDATA;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R8: framing strobe closes the transaction
  a_r8_end_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_xfer |=> (state_q == ST_IDLE));

  // R2: sub-address byte moves to data phase
  a_r2_sub_to_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_base_o |=> (state_q == ST_WDATA));

  // R6: read match enters read phase
  a_r6_enter_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload_o && rw_i) |=> (state_q == ST_READ));
endmodule

// File: rtl/bufptr_ptrs.sv
module bufptr_ptrs #(
  parameter int PTR_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic             load_base_i,
  input  logic [PTR_W-1:0] sub_addr_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] base_o,
  output logic [PTR_W-1:0] cur_o
);
  logic [PTR_W-1:0] base_q, cur_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      if (load_base_i) base_q <= sub_addr_i;
      if (reload_i)         cur_q <= base_q;
      else if (load_base_i) cur_q <= sub_addr_i;
      else if (inc_i)       cur_q <= cur_q + 1'b1; // natural wrap
    end
  end

  assign base_o = base_q;
  assign cur_o  = cur_q;

  // R9: base only moves on sub-address load
  a_r9_base_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_base_i |=> (base_q == $past(base_q)));

  // R5: match reloads current from base
  a_r5_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (cur_q == $past(base_q)));

  // R4: increment wraps
  a_r4_inc_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !reload_i && !load_base_i) |=> (cur_q == PTR_W'($past(cur_q) + 1'b1)));

  // R2: both pointers take the sub-address
  a_r2_load_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_base_i && !reload_i) |=> (base_q == cur_q));
endmodule

// File: rtl/bufptr_mem.sv
module bufptr_mem #(
  parameter int PTR_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << PTR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[addr_i] <= wdata_i;
    end
  end

  // same-cycle read for the transmit request
  assign rdata_o = mem_q[addr_i];

  // R3: written byte lands at the addressed slot
  a_r3_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (mem_q[$past(addr_i)] == $past(wdata_i)));
endmodule

// File: rtl/i2c_bufptr_ctrl.sv
module i2c_bufptr_ctrl #(
  parameter int PTR_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              addr_match_i,
  input  logic              rw_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              tx_req_i,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic [PTR_W-1:0]  base_ptr_o,
  output logic [PTR_W-1:0]  cur_ptr_o
);
  logic reload, load_base, wr_en, rd_inc;

  bufptr_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .addr_match_i (addr_match_i),
    .rw_i         (rw_i),
    .rx_valid_i   (rx_valid_i),
    .tx_req_i     (tx_req_i),
    .reload_o     (reload),
    .load_base_o  (load_base),
    .wr_en_o      (wr_en),
    .rd_inc_o     (rd_inc)
  );

  bufptr_ptrs #(.PTR_W(PTR_W)) u_ptrs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reload_i    (reload),
    .load_base_i (load_base),
    .sub_addr_i  (rx_byte_i[PTR_W-1:0]),
    .inc_i       (wr_en | rd_inc),
    .base_o      (base_ptr_o),
    .cur_o       (cur_ptr_o)
  );

  bufptr_mem #(.PTR_W(PTR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .addr_i  (cur_ptr_o),
    .wdata_i (rx_byte_i),
    .rdata_o (tx_byte_o)
  );

  // R8: stray bytes outside a transaction leave pointers alone
  a_r8_stray_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !addr_match_i) |=> ##1 ((rx_valid_i || tx_req_i) && !addr_match_i && !start_i
      |=> (cur_ptr_o == $past(cur_ptr_o))));
endmodule

// File: tb/i2c_bufptr_ctrl_tb.sv
module i2c_bufptr_ctrl_tb;
  logic       clk = 0;
  logic       rst_ni = 0;
  logic       start_i = 0, stop_i = 0, addr_match_i = 0, rw_i = 0;
  logic       rx_valid_i = 0, tx_req_i = 0;
  logic [7:0] rx_byte_i = '0;
  logic [7:0] tx_byte_o;
  logic [4:0] base_ptr_o, cur_ptr_o;

  always #5 clk = ~clk;

  i2c_bufptr_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
    .addr_match_i(addr_match_i), .rw_i(rw_i), .rx_valid_i(rx_valid_i),
    .rx_byte_i(rx_byte_i), .tx_req_i(tx_req_i), .tx_byte_o(tx_byte_o),
    .base_ptr_o(base_ptr_o), .cur_ptr_o(cur_ptr_o)
  );

  int total = 0, bad = 0;
  logic [7:0] exp_mem [32];
  logic [4:0] exp_base = '0, exp_cur = '0;
  int mode = 0; // 0 idle, 1 sub, 2 write data, 3 read
  logic [7:0] exp_q [$];
  string tx_tag = "R6";

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ptrs(string req);
    #1;
    chk({req, " base"}, base_ptr_o, exp_base);
    chk({req, " cur"}, cur_ptr_o, exp_cur);
  endtask

  task automatic ev_start();
    @(negedge clk); start_i = 1;
    @(negedge clk); start_i = 0;
    mode = 0;
  endtask

  task automatic ev_stop();
    @(negedge clk); stop_i = 1;
    @(negedge clk); stop_i = 0;
    mode = 0;
  endtask

  task automatic ev_addr(bit rd);
    @(negedge clk); addr_match_i = 1; rw_i = rd;
    @(negedge clk); addr_match_i = 0; rw_i = 0;
    mode = rd ? 3 : 1;
    exp_cur = exp_base;
  endtask

  task automatic ev_byte(logic [7:0] b);
    @(negedge clk); rx_valid_i = 1; rx_byte_i = b;
    @(negedge clk); rx_valid_i = 0;
    if (mode == 1) begin
      exp_base = b[4:0]; exp_cur = b[4:0]; mode = 2;
    end else if (mode == 2) begin
      exp_mem[exp_cur] = b; exp_cur = exp_cur + 1'b1;
    end
  endtask

  task automatic ev_tx();
    @(negedge clk);
    if (mode == 3) begin
      exp_q.push_back(exp_mem[exp_cur]);
      exp_cur = exp_cur + 1'b1;
    end
    tx_req_i = 1;
    @(negedge clk); tx_req_i = 0;
  endtask

  // monitor: compares transmit data while the request is high
  initial begin
    forever begin
      @(negedge clk); #2;
      if (tx_req_i && exp_q.size() > 0) chk(tx_tag, tx_byte_o, exp_q.pop_front());
    end
  end

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) exp_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    chk_ptrs("R1");
    #1 chk("R1 buf", tx_byte_o, 8'h00);

    // R2/R3 write sub 5 then three bytes
    ev_start(); ev_addr(0);
    chk_ptrs("R5 write match");
    ev_byte(8'h05); chk_ptrs("R2");
    ev_byte(8'hA1); ev_byte(8'hB2); ev_byte(8'hC3);
    chk_ptrs("R3 R9");
    ev_stop();

    // R6 read back without resending sub-address
    ev_start(); ev_addr(1); chk_ptrs("R5 read match");
    tx_tag = "R6 R3";
    ev_tx(); ev_tx(); ev_tx();
    chk_ptrs("R6 R9");
    // repeated start reloads
    ev_start(); ev_addr(1); chk_ptrs("R5 restart");
    ev_tx(); chk_ptrs("R6");
    ev_stop();

    // R4 wrap, R2 upper bits discarded (0xFE -> 30)
    ev_start(); ev_addr(0); ev_byte(8'hFE); chk_ptrs("R2 upper");
    ev_byte(8'hD0); ev_byte(8'hD1); ev_byte(8'hD2); ev_byte(8'hD3);
    chk_ptrs("R4 write wrap");
    ev_stop();
    ev_start(); ev_addr(1);
    tx_tag = "R4 R6";
    ev_tx(); ev_tx(); ev_tx(); ev_tx();
    chk_ptrs("R4 read wrap");
    ev_stop();

    // R7 sub-address only
    ev_start(); ev_addr(0); ev_byte(8'h0A); ev_stop();
    chk_ptrs("R7");
    // R8 stray events after stop
    ev_byte(8'h77); ev_tx(); chk_ptrs("R8 stop");
    ev_start(); ev_byte(8'h66); ev_tx(); chk_ptrs("R8 start");
    // write match then stop without bytes: base unchanged
    ev_start(); ev_addr(0); ev_stop(); chk_ptrs("R9 empty write");

    // full read sweep verifies buffer contents (R7, R8 no writes)
    ev_start(); ev_addr(1);
    tx_tag = "R7 R8 sweep";
    for (int i = 0; i < 32; i++) ev_tx();
    chk_ptrs("R6 sweep");
    ev_stop();
    @(negedge clk); #3;
    chk("R6 drained", exp_q.size(), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule